// File: doc/BRIEF.md
# I2C Paged Byte Memory Target

This block is an I2C target that serves a 2048-byte memory held inside the block. The memory is split into eight pages of 256 bytes. A bus master selects a page with three bits of the device address byte. It selects a byte inside the page with a word-address byte, which the target keeps in an internal latch. That latch is not cleared between transactions and steps forward after every byte that moves. A read that sends no word address therefore picks up just after the last byte touched, whether that byte was read or written.

The block samples SCL and SDA with a system clock that runs much faster than SCL. It drives SDA as an open-drain output: when `sda_oe` is high, an external pad pulls the line low. Writes can carry one byte or many. Reads can start at the current address, run sequentially for any length, or start at a chosen address by writing a word address, sending a repeated START and then addressing the device for a read.

Top module: `i2c_paged_mem`

## Requirements
- R1: The target answers only when bits [7:4] of the device address byte equal 4'b1010. For any other value it does not ACK, and it leaves SDA released until the next START.
- R2: Bit 0 of the device address byte sets the direction: 1 means a read and 0 means a write.
- R3: Bits [3:1] of the device address byte become memory address bits [10:8]. In a write, the first byte after the device address is loaded into address bits [7:0].
- R4: In a write, every data byte after the word address is stored at the current address. The target ACKs the device address, the word address and every data byte by pulling SDA low during the 9th clock.
- R5: The 11-bit address steps by one after each data byte, whether written or read. It carries from the low byte into the page bits, and 7FFh is followed by 000h.
- R6: A read without a preceding word address starts at the byte after the last one accessed, with the page bits taken from the new device address byte.
- R7: A write-direction device byte plus a word address, followed by a repeated START and a read-direction device byte, starts the read at that word address.
- R8: In a read, data goes out MSB first. A master ACK in the 9th clock makes the target send the next byte. A NACK ends the transfer, and the target leaves SDA released.
- R9: If a STOP or a START arrives in the 9th clock of a read, the read ends and the target drives no more data.
- R10: The target changes `sda_oe` only just after a falling edge of SCL. The one exception is a release caused by a START or a STOP.
- R11: While reset is held and after it is released, `sda_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | I2C clock line as seen at the pin |
| sda_in | input | 1 | I2C data line as seen at the pin |
| sda_oe | output | 1 | High pulls SDA low (open drain) |

## Verification
The assertions check on every cycle that `sda_oe` moves only after a synchronised SCL falling edge or a bus condition, and that SDA is released after a START or a STOP. They also check that the target never drives SDA while it ignores a foreign transaction, that every stored byte coincides with an ACK, and that the address has already moved one step past each written location. Only the bench's scenarios can show the rest. These are the stored contents, page carry and the 7FFh wrap, current-address reads that continue after writes and after reads, selective reads through a repeated START, and the three ways a read can end. In those scenarios the bench compares every returned byte and every ACK with a behavioural memory model.

// File: rtl/i2cpm_pkg.sv
package i2cpm_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_WORD,
    PH_WR,
    PH_RD,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/i2cpm_sync.sv
module i2cpm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_cond,
  output logic stop_cond
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s      = scl_pipe[STAGES-1];
  assign sda_s      = sda_pipe[STAGES-1];
  assign scl_rise   = scl_s & ~scl_q;
  assign scl_fall   = ~scl_s & scl_q;
  // conditions only count while SCL stays high across both samples
  assign start_cond = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_cond  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cpm_store.sv
module i2cpm_store #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/i2cpm_ctrl.sv
module i2cpm_ctrl
  import i2cpm_pkg::*;
#(
  parameter int AW = 11,
  parameter int PW = 3,
  parameter int DW = 8,
  parameter logic [DW-PW-2:0] DEV_ID = 4'b1010
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_cond,
  input  logic          stop_cond,
  input  logic [DW-1:0] rdata,
  output logic          sda_oe,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata,
  output logic [AW-1:0] cur_addr,
  output logic          ignoring
);
  localparam int IDW = DW - PW - 1;
  localparam int LW  = AW - PW;
  localparam int CW  = $clog2(DW + 2);
  localparam int IW  = $clog2(DW);
  localparam logic [CW-1:0] ACK_SLOT = CW'(DW);
  localparam logic [CW-1:0] AFTER_ACK = CW'(DW + 1);

  phase_t        phase;
  logic [CW-1:0] bitcnt;
  logic [DW-1:0] shreg, txreg;
  logic          rd_dir, mack;
  logic [AW-1:0] addr;
  logic [IW-1:0] tx_idx;

  assign tx_idx   = IW'(DW - 1) - bitcnt[IW-1:0];
  assign cur_addr = addr;
  assign ignoring = (phase == PH_SKIP);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      txreg     <= '0;
      rd_dir    <= 1'b0;
      mack      <= 1'b0;
      addr      <= '0;
      sda_oe    <= 1'b0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (stop_cond) begin
        phase  <= PH_IDLE;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (start_cond) begin
        phase  <= PH_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (phase)
          PH_DEV, PH_WORD, PH_WR: begin
            if (scl_rise && bitcnt < ACK_SLOT) begin
              shreg  <= {shreg[DW-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == ACK_SLOT) begin
              bitcnt <= AFTER_ACK;
              sda_oe <= 1'b1;
              if (phase == PH_DEV) begin
                if (shreg[DW-1 -: IDW] == DEV_ID) begin
                  addr[AW-1 -: PW] <= shreg[PW:1];
                  rd_dir           <= shreg[0];
                end else begin
                  phase  <= PH_SKIP;
                  sda_oe <= 1'b0;
                end
              end else if (phase == PH_WORD) begin
                addr[LW-1:0] <= shreg[LW-1:0];
              end else begin
                mem_we    <= 1'b1;
                mem_waddr <= addr;
                mem_wdata <= shreg;
                addr      <= addr + 1'b1;
              end
            end else if (scl_fall && bitcnt == AFTER_ACK) begin
              bitcnt <= '0;
              sda_oe <= 1'b0;
              if (phase == PH_DEV && rd_dir) begin
                phase  <= PH_RD;
                txreg  <= rdata;
                sda_oe <= ~rdata[DW-1];
                addr   <= addr + 1'b1;
              end else if (phase == PH_DEV) begin
                phase <= PH_WORD;
              end else begin
                phase <= PH_WR;
              end
            end
          end
          PH_RD: begin
            if (scl_rise) begin
              if (bitcnt == ACK_SLOT) mack <= ~sda_s;
              if (bitcnt < AFTER_ACK) bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall) begin
              if (bitcnt == ACK_SLOT) begin
                sda_oe <= 1'b0;
              end else if (bitcnt == AFTER_ACK) begin
                if (mack) begin
                  txreg  <= rdata;
                  sda_oe <= ~rdata[DW-1];
                  addr   <= addr + 1'b1;
                  bitcnt <= '0;
                end else begin
                  phase  <= PH_SKIP;
                  sda_oe <= 1'b0;
                end
              end else if (bitcnt != '0) begin
                sda_oe <= ~txreg[tx_idx];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_paged_mem.sv
module i2c_paged_mem #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 3,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [DATA_W-PAGE_W-2:0] DEV_ID = 4'b1010
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_oe
);
  logic              sda_s, scl_rise, scl_fall, start_cond, stop_cond;
  logic              mem_we, ignoring;
  logic [ADDR_W-1:0] mem_waddr, cur_addr;
  logic [DATA_W-1:0] mem_wdata, rdata;

  i2cpm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_cond(start_cond), .stop_cond(stop_cond)
  );

  i2cpm_ctrl #(.AW(ADDR_W), .PW(PAGE_W), .DW(DATA_W), .DEV_ID(DEV_ID)) u_ctrl (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_cond(start_cond), .stop_cond(stop_cond),
    .rdata(rdata), .sda_oe(sda_oe), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .cur_addr(cur_addr), .ignoring(ignoring)
  );

  i2cpm_store #(.AW(ADDR_W), .DW(DATA_W)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(cur_addr), .rdata(rdata)
  );
endmodule

// File: rtl/i2cpm_chk.sv
module i2cpm_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_fall,
  input logic          start_cond,
  input logic          stop_cond,
  input logic          sda_oe,
  input logic          mem_we,
  input logic [AW-1:0] mem_waddr,
  input logic [AW-1:0] cur_addr,
  input logic          ignoring
);
  AST_OE_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> $past(scl_fall || start_cond || stop_cond)); // R10

  AST_RELEASE_ON_COND: assert property (@(posedge clk) disable iff (rst)
    (start_cond || stop_cond) |=> !sda_oe); // R9

  AST_FOREIGN_SILENT: assert property (@(posedge clk) disable iff (rst)
    ignoring |-> !sda_oe); // R1

  AST_WRITE_ACKED: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> sda_oe); // R4

  AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we); // R4

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> cur_addr == AW'(mem_waddr + 1'b1)); // R5

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> !sda_oe); // R11
endmodule

bind i2c_paged_mem i2cpm_chk #(.AW(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .scl_fall(scl_fall), .start_cond(start_cond),
  .stop_cond(stop_cond), .sda_oe(sda_oe), .mem_we(mem_we),
  .mem_waddr(mem_waddr), .cur_addr(cur_addr), .ignoring(ignoring)
);

// File: tb/sim_i2c_paged_mem.sv
`timescale 1ns/1ps
module sim_i2c_paged_mem;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  bit quiet = 1'b1;
  bit done = 1'b0;
  logic prev_oe = 1'b0;

  logic [7:0] mem_m [0:2047];
  int addr_m = 0;
  logic [7:0] wq[$];

  always #2 clk = ~clk;

  i2c_paged_mem u0 (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line), .sda_oe(sda_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model's view of when SDA may move
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (quiet) chk(!sda_oe, "R1 target silent while idle/ignored", sda_oe, 0);
      if (sda_oe != prev_oe) chk(!scl, "R10 sda_oe change with SCL low", scl, 0);
      prev_oe = sda_oe;
    end
  end

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, output logic r);
    sda_m = b; waitq();
    scl = 1'b1; waitq();
    r = sda_line;
    scl = 1'b0; waitq();
  endtask

  task automatic start_c();
    sda_m = 1'b1; waitq();
    scl = 1'b1; waitq();
    sda_m = 1'b0; waitq();
    scl = 1'b0; waitq();
  endtask

  task automatic stop_c();
    sda_m = 1'b0; waitq();
    scl = 1'b1; waitq();
    sda_m = 1'b1; waitq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_x(b[i], r);
    bit_x(1'b1, r);
    ack = !r;
  endtask

  task automatic recv8(output logic [7:0] b);
    logic r;
    for (int i = 0; i < 8; i++) begin
      bit_x(1'b1, r);
      b = {b[6:0], r};
    end
  endtask

  task automatic begin_txn();
    start_c();
    quiet = 1'b0;
  endtask

  task automatic end_txn();
    stop_c();
    quiet = 1'b1;
  endtask

  task automatic dev_byte(input int page, input bit rd, input string req);
    bit ack;
    send_byte({4'b1010, page[2:0], rd}, ack);
    chk(ack, req, ack, 1);
  endtask

  // write transaction: word address then the bytes in wq
  task automatic wr_txn(input int page, input int word);
    bit ack;
    begin_txn();
    dev_byte(page, 1'b0, "R2 write-direction device ACK");
    send_byte(word[7:0], ack);
    chk(ack, "R3 word address ACK", ack, 1);
    addr_m = page * 256 + word;
    foreach (wq[i]) begin
      send_byte(wq[i], ack);
      chk(ack, "R4 data byte ACK", ack, 1);
      mem_m[addr_m] = wq[i];
      addr_m = (addr_m + 1) % 2048;
    end
    end_txn();
    wq.delete();
  endtask

  // read n bytes; endm 0: NACK+STOP, 1: STOP in 9th clock, 2: START in 9th clock
  task automatic rd_seq(input int n, input int endm, input string req);
    logic [7:0] b;
    logic r;
    for (int i = 0; i < n; i++) begin
      recv8(b);
      chk(b === mem_m[addr_m], req, b, mem_m[addr_m]);
      addr_m = (addr_m + 1) % 2048;
      if (i < n - 1) begin
        bit_x(1'b0, r);
      end else if (endm == 0) begin
        bit_x(1'b1, r);
        chk(!sda_oe, "R8 released after NACK", sda_oe, 0);
        end_txn();
      end else if (endm == 1) begin
        end_txn();
        chk(!sda_oe, "R9 released after STOP in 9th clock", sda_oe, 0);
      end else begin
        start_c();
        chk(!sda_oe, "R9 released after START in 9th clock", sda_oe, 0);
      end
    end
  endtask

  task automatic cur_read(input int page, input int n, input int endm, input string req);
    begin_txn();
    dev_byte(page, 1'b1, "R2 read-direction device ACK");
    addr_m = page * 256 + (addr_m % 256);
    rd_seq(n, endm, req);
  endtask

  task automatic sel_read(input int page, input int word, input int n, input int endm,
                          input bit fresh, input string req);
    bit ack;
    if (fresh) begin_txn();
    dev_byte(page, 1'b0, "R7 selective write-phase ACK");
    send_byte(word[7:0], ack);
    chk(ack, "R7 selective word ACK", ack, 1);
    start_c();
    dev_byte(page, 1'b1, "R7 read after repeated START ACK");
    addr_m = page * 256 + word;
    rd_seq(n, endm, req);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    bit ack;
    repeat (8) @(negedge clk);
    chk(!sda_oe, "R11 sda_oe low in reset", sda_oe, 0);
    rst = 1'b0;
    repeat (8) @(negedge clk);
    chk(!sda_oe, "R11 sda_oe low after reset", sda_oe, 0);

    // single write, page 2 word 10h
    wq.push_back(8'hA5);
    wr_txn(2, 8'h10);
    // multi write crossing page 5 into page 6 (R5 carry)
    wq.push_back(8'h11); wq.push_back(8'h22); wq.push_back(8'h33);
    wr_txn(5, 8'hFE);
    // wrap 7FFh -> 000h
    wq.push_back(8'hC4); wq.push_back(8'h7E); wq.push_back(8'h5B);
    wr_txn(7, 8'hFF);
    // current read continuing after a write (R6)
    wq.push_back(8'hD1); wq.push_back(8'hD2);
    wr_txn(3, 8'h40);
    wq.push_back(8'hE0);
    wr_txn(3, 8'h40);
    cur_read(3, 1, 0, "R6 current read after write");
    // selective read across page carry, then current read after a read
    sel_read(5, 8'hFE, 2, 0, 1'b1, "R7 selective read data");
    cur_read(6, 1, 0, "R6 current read after read (R5 carry)");
    // wrap on read, ended by STOP in 9th clock
    sel_read(7, 8'hFF, 2, 1, 1'b1, "R5 read wrap 7FFh to 000h");
    // current read ended by START in 9th clock, then a selective read
    cur_read(0, 1, 2, "R9 current read before START in 9th");
    sel_read(2, 8'h10, 1, 0, 1'b0, "R9 read after START in 9th");
    // foreign device address: no ACK, no drive
    start_c();
    send_byte(8'h92, ack);
    chk(!ack, "R1 foreign address not ACKed", ack, 0);
    send_byte(8'h00, ack);
    chk(!ack, "R1 following byte ignored", ack, 0);
    stop_c();
    sel_read(2, 8'h10, 1, 0, 1'b1, "R1 target answers after foreign transfer");
    sel_read(5, 8'hFE, 3, 0, 1'b1, "R8 sequential read with ACKs");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule